// File: doc/BRIEF.md
# Peripheral Pin Remapping Crossbar

This block sits between a group of remappable I/O pins and the digital peripherals that share them. In one direction, each peripheral input has a 6-bit selector that names the pin it listens to. The pin value reaches the peripheral through pure combinational logic. In the other direction, each pin has a function code. The code picks which peripheral output drives the pin's data, or it leaves the pin to the port's own output latch.

Software programs the selectors and function codes through a small synchronous register interface. Once the mapping is right, software sets a lock bit that freezes every selector and code. The lock bit can only be changed inside a short window that opens after a two-word key sequence. Pin direction belongs to the port block, and the crossbar passes it through without changing it.

Address map, with each register 16 bits wide:
- Address 0 is the key register. It is write-only and reads as 0.
- Address 1 is the lock register, with the lock in bit 0.
- Addresses 2 to 4 are the input selector registers.
- Addresses 5 to 12 are the per-pin output code registers, one per pin.

Top module: `pinmux_xbar`

## Requirements
- R1: Peripheral input i follows `pin_in[sel_i]` combinationally. The field `sel_i` sits in register 2+i/2: bits 5:0 for even i and bits 13:8 for odd i.
- R2: A selector value of 8 or more (past the last pin) makes that peripheral input read 0. Every selector resets to 63, so after reset all peripheral inputs are 0.
- R3: Bits 7:6 and 15:14 of a selector register always read 0. The high field of register 4 has no input behind it: writes to it are dropped and it reads 0.
- R4: The code for pin p is held in bits 5:0 of register 5+p.
  - Code 0 gives `pin_out[p] = port_lat[p]`.
  - Codes 1 to 4 give `periph_out[code-1]`. In order these are comparator 1, comparator 2, serial transmit and serial request-to-send.
  - Any larger code also gives the latch value.
- R5: After reset every output code reads 0 and `pin_out` equals `port_lat`.
- R6: Pins 6 and 7 are input-only. Writes to their code registers have no effect, the registers read 0, and their `pin_out` is always the latch value.
- R7: While the lock bit is 1, writes to every selector register and code register are ignored.
- R8: A write to the lock register is accepted only in the two cycles after the key register received 0x46 and then 0x57 in consecutive cycles.
- R9: A gap between the two key words, or the words in the wrong order, leaves the sequence unarmed, and a following lock write is ignored.
- R10: The lock bit resets to 0 and keeps its value until an accepted lock write changes it.
- R11: `pin_oe` equals `port_dir_out` whatever the mapping is.
- R12: A register write changes routing and readback at the clock edge that captures it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data at `reg_addr` |
| pin_in | input | 8 | Values sampled at the remappable pins |
| periph_out | input | 4 | Peripheral outputs selectable by codes 1 to 4 |
| port_lat | input | 8 | Port output latch per pin |
| port_dir_out | input | 8 | Port direction per pin, 1 = output |
| periph_in | output | 5 | Routed peripheral inputs |
| pin_out | output | 8 | Final per-pin output data |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A corrupted selector shows up at once as a peripheral input that follows the wrong pin, or that is stuck at 0 when the pin toggles. A corrupted output code shows up as a pin that carries a peripheral signal where it should carry the latch. Both kinds of error appear in the same cycle the pins are driven, and both also appear in readback one edge after the write. A fault in the key sequence or the lock appears as a lock value that reads back wrongly right after the lock write. It can also appear as a selector that changes while locked. This is why every window boundary and every broken sequence is followed by a readback.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int SEL_W      = 6;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 8;
    localparam int HI_LSB     = 8;
    localparam int ADDR_KEY   = 0;
    localparam int ADDR_LOCK  = 1;
    localparam int IN_BASE    = 2;
    localparam int UNLOCK_WIN = 2;
    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h0046;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'h0057;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_ARMED = 2'd1,
        UL_OPEN  = 2'd2
    } unlock_st_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } cfg_wr_t;

    function automatic int in_reg_count(input int n_inputs);
        return (n_inputs + 1) / 2;
    endfunction
endpackage

// File: rtl/pinmux_unlock.sv
module pinmux_unlock
    import pinmux_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t wr,
    output logic    locked
);
    localparam int CW = $clog2(UNLOCK_WIN + 1);

    unlock_st_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic lock_q;
    logic key_wr, lock_wr;

    assign key_wr  = wr.en && (wr.addr == ADDR_W'(ADDR_KEY));
    assign lock_wr = wr.en && (wr.addr == ADDR_W'(ADDR_LOCK)) && (st_q == UL_OPEN);

    always_comb begin
        st_d  = UL_IDLE;
        cnt_d = '0;
        if (key_wr && wr.data == KEY_FIRST) begin
            st_d = UL_ARMED;
        end else begin
            unique case (st_q)
                UL_ARMED: if (key_wr && wr.data == KEY_SECOND) st_d = UL_OPEN;
                UL_OPEN: begin
                    if (cnt_q != CW'(UNLOCK_WIN - 1)) begin
                        st_d  = UL_OPEN;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= UL_IDLE;
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (lock_wr) lock_q <= wr.data[0];
        end
    end

    assign locked = lock_q;

    // R8
    lock_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q != $past(lock_q)) |-> ($past(st_q) == UL_OPEN));

    // R9
    open_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == UL_OPEN && $past(st_q) != UL_OPEN) |->
        ($past(st_q) == UL_ARMED && $past(wr.en) &&
         $past(wr.addr) == ADDR_W'(ADDR_KEY) && $past(wr.data) == KEY_SECOND));
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS      = 8,
    parameter int NUM_PERIPH_IN = 5,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'hC0
) (
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t wr,
    input  logic    locked,
    output logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] in_sel,
    output logic [NUM_PINS-1:0][SEL_W-1:0]      out_code,
    output logic [REG_W-1:0]                    rdata
);
    localparam int IN_REGS  = in_reg_count(NUM_PERIPH_IN);
    localparam int OUT_BASE = IN_BASE + IN_REGS;

    logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] in_sel_q;
    logic [NUM_PINS-1:0][SEL_W-1:0]      out_code_q;
    logic [IN_REGS-1:0][REG_W-1:0]       in_word;
    logic unused_bits;

    assign unused_bits = ^{wr.data[REG_W-1:HI_LSB+SEL_W], wr.data[HI_LSB-1:SEL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sel_q   <= '1;
            out_code_q <= '0;
        end else if (wr.en && !locked) begin
            for (int i = 0; i < NUM_PERIPH_IN; i++) begin
                if (wr.addr == ADDR_W'(IN_BASE + i / 2))
                    in_sel_q[i] <= (i % 2 == 1) ? wr.data[HI_LSB +: SEL_W] : wr.data[SEL_W-1:0];
            end
            for (int p = 0; p < NUM_PINS; p++) begin
                if (!INPUT_ONLY_MASK[p] && wr.addr == ADDR_W'(OUT_BASE + p))
                    out_code_q[p] <= wr.data[SEL_W-1:0];
            end
        end
    end

    for (genvar r = 0; r < IN_REGS; r++) begin : g_word
        if (2 * r + 1 < NUM_PERIPH_IN) begin : g_pair
            assign in_word[r] = REG_W'({in_sel_q[2*r+1], {(HI_LSB-SEL_W){1'b0}}, in_sel_q[2*r]});
        end else begin : g_single
            assign in_word[r] = REG_W'(in_sel_q[2*r]);
        end
    end

    always_comb begin
        rdata = '0;
        if (wr.addr == ADDR_W'(ADDR_LOCK)) rdata[0] = locked;
        for (int r = 0; r < IN_REGS; r++)
            if (wr.addr == ADDR_W'(IN_BASE + r)) rdata = in_word[r];
        for (int p = 0; p < NUM_PINS; p++)
            if (wr.addr == ADDR_W'(OUT_BASE + p)) rdata = REG_W'(out_code_q[p]);
    end

    assign in_sel   = in_sel_q;
    assign out_code = out_code_q;

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(in_sel_q) && $stable(out_code_q)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> ($stable(in_sel_q) && $stable(out_code_q)));
endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS      = 8,
    parameter int NUM_PERIPH_IN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] in_sel,
    input  logic [NUM_PINS-1:0]                 pin_in,
    output logic [NUM_PERIPH_IN-1:0]            periph_in
);
    for (genvar i = 0; i < NUM_PERIPH_IN; i++) begin : g_in
        always_comb begin
            periph_in[i] = 1'b0;
            for (int p = 0; p < NUM_PINS; p++)
                if (in_sel[i] == SEL_W'(p)) periph_in[i] = pin_in[p];
        end

        // R2
        oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (in_sel[i] >= SEL_W'(NUM_PINS)) |-> (periph_in[i] == 1'b0));
    end
endmodule

// File: rtl/pinmux_out_route.sv
module pinmux_out_route
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS      = 8,
    parameter int NUM_OUT_FUNCS = 4,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'hC0
) (
    input  logic clk,
    input  logic rst,
    input  logic [NUM_PINS-1:0][SEL_W-1:0] out_code,
    input  logic [NUM_OUT_FUNCS-1:0]       periph_out,
    input  logic [NUM_PINS-1:0]            port_lat,
    output logic [NUM_PINS-1:0]            pin_out
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            pin_out[p] = port_lat[p];
            for (int k = 1; k <= NUM_OUT_FUNCS; k++)
                if (out_code[p] == SEL_W'(k)) pin_out[p] = periph_out[k-1];
        end

        if (INPUT_ONLY_MASK[p]) begin : g_ionly
            // R6
            ionly_latch_chk: assert property (@(posedge clk) disable iff (rst)
                pin_out[p] == port_lat[p]);
        end
    end
endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS      = 8,
    parameter int NUM_PERIPH_IN = 5,
    parameter int NUM_OUT_FUNCS = 4,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'hC0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [NUM_PINS-1:0]      pin_in,
    input  logic [NUM_OUT_FUNCS-1:0] periph_out,
    input  logic [NUM_PINS-1:0]      port_lat,
    input  logic [NUM_PINS-1:0]      port_dir_out,
    output logic [NUM_PERIPH_IN-1:0] periph_in,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe
);
    cfg_wr_t wr;
    logic    locked;
    logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] in_sel;
    logic [NUM_PINS-1:0][SEL_W-1:0]      out_code;

    assign wr = '{en: reg_we, addr: reg_addr, data: reg_wdata};

    pinmux_unlock u_unlock (
        .clk(clk), .rst(rst), .wr(wr), .locked(locked)
    );

    pinmux_regs #(
        .NUM_PINS(NUM_PINS), .NUM_PERIPH_IN(NUM_PERIPH_IN), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .locked(locked),
        .in_sel(in_sel), .out_code(out_code), .rdata(reg_rdata)
    );

    pinmux_in_route #(
        .NUM_PINS(NUM_PINS), .NUM_PERIPH_IN(NUM_PERIPH_IN)
    ) u_in (
        .clk(clk), .rst(rst), .in_sel(in_sel), .pin_in(pin_in), .periph_in(periph_in)
    );

    pinmux_out_route #(
        .NUM_PINS(NUM_PINS), .NUM_OUT_FUNCS(NUM_OUT_FUNCS), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)
    ) u_out (
        .clk(clk), .rst(rst), .out_code(out_code), .periph_out(periph_out),
        .port_lat(port_lat), .pin_out(pin_out)
    );

    // R11: direction is owned by the port block
    assign pin_oe = port_dir_out;
endmodule

// File: tb/pinmux_xbar_bench.sv
module pinmux_xbar_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NI = 5;
    localparam int NF = 4;
    localparam logic [NP-1:0] IO_MASK = 8'hC0;
    localparam int A_KEY = 0;
    localparam int A_LOCK = 1;
    localparam int A_IN = 2;
    localparam int A_OUT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NF-1:0] periph_out = '0;
    logic [NP-1:0] port_lat = '0;
    logic [NP-1:0] port_dir_out = '0;
    logic [NI-1:0] periph_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pinmux_xbar u_pinmux_xbar (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .periph_out(periph_out), .port_lat(port_lat), .port_dir_out(port_dir_out),
        .periph_in(periph_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 8'(addr);
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_chk(input int addr, input logic [15:0] exp, input string req);
        reg_addr = 8'(addr);
        #1;
        chk(reg_rdata == exp, req, 32'(reg_rdata), 32'(exp));
    endtask

    function automatic logic [NP-1:0] exp_pins(input int p, input int code,
                                               input logic [NF-1:0] po, input logic [NP-1:0] lat);
        logic [NP-1:0] res = lat;
        int eff = IO_MASK[p] ? 0 : code;
        if (eff >= 1 && eff <= NF) res[p] = po[eff-1];
        return res;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R2 R5 R10 R3 reset state
        pin_in = 8'hFF; port_lat = 8'h5A; periph_out = 4'hF;
        #1;
        chk(periph_in == '0, "R2 reset inputs", 32'(periph_in), 0);
        chk(pin_out == 8'h5A, "R5 reset pins", 32'(pin_out), 32'h5A);
        rd_chk(A_LOCK, 16'h0000, "R10 reset lock");
        rd_chk(A_IN, 16'h3F3F, "R3 reset selector reg");
        rd_chk(A_IN + 2, 16'h003F, "R3 last reg high field");
        for (int p = 0; p < NP; p++) rd_chk(A_OUT + p, 16'h0000, "R5 reset code");

        // R1 R2 R3 R12 selector sweep
        for (int i = 0; i < NI; i++) begin
            for (int s = 0; s < 64; s++) begin
                logic [15:0] w;
                logic [15:0] expw;
                if (i % 2 == 0) w = {2'b11, 6'h3F, 2'b11, 6'(s)};
                else            w = {2'b11, 6'(s), 2'b11, 6'h3F};
                wr(A_IN + i / 2, w);
                expw = {2'b00, w[13:8], 2'b00, w[5:0]};
                if (i / 2 == 2) expw[15:8] = 8'h00;
                rd_chk(A_IN + i / 2, expw, "R3 selector readback");
                foreach (pin_in[k]) ;
                for (int j = 0; j < 2; j++) begin
                    logic [NI-1:0] e = '0;
                    pin_in = j ? 8'h5A : 8'hA5;
                    if (s < NP) e[i] = pin_in[s];
                    #1;
                    chk(periph_in == e, (s < NP) ? "R1 R12 route" : "R2 out of range",
                        32'(periph_in), 32'(e));
                end
            end
        end

        // R4 R6 R11 output sweep
        for (int p = 0; p < NP; p++) begin
            for (int code = 0; code < 8; code++) begin
                wr(A_OUT + p, 16'hFFC0 | 16'(code));
                rd_chk(A_OUT + p, IO_MASK[p] ? 16'h0 : 16'(code), IO_MASK[p] ? "R6 readback" : "R4 readback");
                for (int j = 0; j < 4; j++) begin
                    logic [NP-1:0] e;
                    periph_out = j[0] ? 4'b1010 : 4'b0101;
                    port_lat = j[1] ? 8'hF0 : 8'h0F;
                    port_dir_out = 8'h3C ^ 8'(j * 17 + code);
                    e = exp_pins(p, code, periph_out, port_lat);
                    #1;
                    chk(pin_out == e, IO_MASK[p] ? "R6 pin output" : "R4 pin output", 32'(pin_out), 32'(e));
                    chk(pin_oe == port_dir_out, "R11 direction", 32'(pin_oe), 32'(port_dir_out));
                end
            end
            wr(A_OUT + p, 16'h0000);
        end

        // R8 lock write without key sequence
        wr(A_LOCK, 16'h0001);
        rd_chk(A_LOCK, 16'h0000, "R8 no key");
        // R9 gap between key words
        wr(A_KEY, 16'h0046); idle(); wr(A_KEY, 16'h0057); wr(A_LOCK, 16'h0001);
        rd_chk(A_LOCK, 16'h0000, "R9 gap");
        // R9 wrong order
        wr(A_KEY, 16'h0057); wr(A_KEY, 16'h0046); wr(A_LOCK, 16'h0001);
        rd_chk(A_LOCK, 16'h0000, "R9 order");
        // R8 window closed after two cycles
        wr(A_KEY, 16'h0046); wr(A_KEY, 16'h0057); idle(); idle(); wr(A_LOCK, 16'h0001);
        rd_chk(A_LOCK, 16'h0000, "R8 window end");
        // R8 last cycle of window
        wr(A_KEY, 16'h0046); wr(A_KEY, 16'h0057); idle(); wr(A_LOCK, 16'h0001);
        rd_chk(A_LOCK, 16'h0001, "R8 window accept");

        // R7 writes ignored while locked
        wr(A_IN, 16'h0100);
        wr(A_OUT, 16'h0003);
        rd_chk(A_IN, 16'h3F3F, "R7 selector frozen");
        rd_chk(A_OUT, 16'h0000, "R7 code frozen");
        pin_in = 8'hFF; port_lat = 8'h00; periph_out = 4'hF;
        #1;
        chk(periph_in == '0, "R7 routing frozen", 32'(periph_in), 0);
        chk(pin_out == 8'h00, "R7 pins frozen", 32'(pin_out), 0);

        // R10 lock holds
        repeat (20) idle();
        wr(A_LOCK, 16'h0000);
        rd_chk(A_LOCK, 16'h0001, "R10 lock holds");

        // R10 R12 unlock then write takes effect
        wr(A_KEY, 16'h0046); wr(A_KEY, 16'h0057); wr(A_LOCK, 16'h0000);
        rd_chk(A_LOCK, 16'h0000, "R10 cleared");
        pin_in = 8'h08;
        wr(A_IN, 16'h3F03);
        #1;
        chk(periph_in == 5'b00001, "R12 write after unlock", 32'(periph_in), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule